// File: doc/BRIEF.md
# Bus Response Timeout and Transmitter Watchdog

This block supervises the timing of a serial command/response bus terminal. When the local transmitter stops sending a word, it arms a response timer. The timer measures the silence in half-microsecond steps against one of four selectable windows: 18.5, 22.5, 50.5 or 128 µs. If the decoder does not report a valid response sync before the window closes, the block emits a one-cycle timeout pulse. A new transmission or a detected sync cancels the timer.

A second counter measures how long the transmitter stays enabled without a break. After about 668 µs of unbroken transmission it latches a transmit inhibit, gates the transmitter off and raises a one-cycle interrupt strobe. The inhibit holds until the host clears it or the block is reset. The half-microsecond time base comes from the system clock through a prescaler. The prescaler has one divider for a 16 MHz clock and one for a 12 MHz clock, and an input selects between them.

Top module: `bus_resp_guard`

## Requirements
- R1: `tmo_sel` picks the response window, in half-µs units: 0 → WIN0 (37), 1 → WIN1 (45), 2 → WIN2 (101), 3 → WIN3 (256). The value is captured when the timer arms, so a later change of `tmo_sel` does not alter a window already running.
- R2: The timer arms at the clock edge that first samples `tx_active` low after it was high. With D the active clock divider and N the window, `resp_timeout` rises between (N-1)·D+1 and N·D clock edges after that arming edge.
- R3: `resp_timeout` is high for exactly one clock cycle per expiry.
- R4: `resp_sync` sampled high while the timer is armed cancels it, and no timeout follows. `resp_sync` while the timer is idle has no effect.
- R5: `tx_active` sampled high cancels a running timer. The next falling edge of `tx_active` starts a fresh full window.
- R6: Unbroken transmission of WDOG_HALF half-µs ticks (default 1336, about 668 µs) trips the watchdog. `tx_irq` pulses for one cycle and `tx_inhibit` sets, between (W-1)·D+1 and W·D edges after the first edge that samples `tx_active` high, where W is WDOG_HALF.
- R7: `tx_gate` equals `tx_active` while `tx_inhibit` is low, and is 0 while `tx_inhibit` is high.
- R8: `tx_inhibit` stays set, with or without `tx_active`, until `inh_clr` is sampled high or reset is applied. A clear takes effect at the next edge and restarts the watchdog count.
- R9: The watchdog count restarts whenever `tx_active` is sampled low, so bursts shorter than the limit never trip it.
- R10: `rate_sel` = 0 uses divider DIV_FAST (default 8, for 16 MHz) and 1 uses DIV_SLOW (default 6, for 12 MHz) to form the half-µs tick.
- R11: After reset, `resp_timeout`, `tx_inhibit` and `tx_irq` are 0 and the response timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 or 16 MHz nominal) |
| rst_n | input | 1 | Active-low master reset, synchronous |
| rate_sel | input | 1 | Clock-rate select: 0 fast divider, 1 slow divider |
| tmo_sel | input | 2 | Response window select |
| tx_active | input | 1 | Transmitter currently sending |
| resp_sync | input | 1 | Valid response sync detected by the decoder |
| inh_clr | input | 1 | Host clear of the latched transmit inhibit |
| resp_timeout | output | 1 | One-cycle response timeout pulse |
| tx_inhibit | output | 1 | Latched transmitter shutdown |
| tx_gate | output | 1 | Transmit enable after the inhibit is applied |
| tx_irq | output | 1 | One-cycle transmitter-timeout interrupt strobe |

## Verification
The bench builds the block with DIV_FAST = 4, DIV_SLOW = 3 and WDOG_HALF = 60, and leaves the four response windows at their default values. The short dividers make a sweep over every window at both clock rates quick, including the full 128 µs window. Each expiry is checked against its arithmetic cycle range. The short watchdog limit brings the trip, the latched inhibit, the host clear and the burst-restart behaviour within a few hundred cycles each.

// File: rtl/bus_resp_guard_pkg.sv
package bus_resp_guard_pkg;

    typedef enum logic [1:0] {
        WIN_A = 2'd0,
        WIN_B = 2'd1,
        WIN_C = 2'd2,
        WIN_D = 2'd3
    } win_sel_e;

    function automatic int unsigned umax2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned umax4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
        return umax2(umax2(a, b), umax2(c, d));
    endfunction

endpackage

// File: rtl/bus_resp_guard_tickgen.sv
module bus_resp_guard_tickgen #(
    parameter int unsigned DIV_FAST = 8,
    parameter int unsigned DIV_SLOW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    output logic half_tick
);
    import bus_resp_guard_pkg::*;

    localparam int unsigned DMAX = umax2(DIV_FAST, DIV_SLOW);
    localparam int unsigned CW   = (DMAX > 1) ? $clog2(DMAX) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t          st_d, st_q;
    logic [CW-1:0] div_m1;

    // R10: divider choice per clock rate
    always_comb begin
        div_m1 = rate_sel ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
        st_d   = st_q;
        if (st_q.cnt >= div_m1) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_tick = (st_q.cnt >= div_m1);

endmodule

// File: rtl/bus_resp_guard_resp.sv
module bus_resp_guard_resp #(
    parameter int unsigned WIN0 = 37,
    parameter int unsigned WIN1 = 45,
    parameter int unsigned WIN2 = 101,
    parameter int unsigned WIN3 = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic       tx_active,
    input  logic       tx_fall,
    input  logic       resp_sync,
    input  logic [1:0] tmo_sel,
    output logic       timeout
);
    import bus_resp_guard_pkg::*;

    localparam int unsigned WMAX = umax4(WIN0, WIN1, WIN2, WIN3);
    localparam int unsigned CW   = $clog2(WMAX + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim_m1;
        logic          pulse;
    } rt_t;

    rt_t           st_d, st_q;
    logic [CW-1:0] sel_lim_m1;

    // R1: window lookup in half-microsecond units
    always_comb begin
        unique case (win_sel_e'(tmo_sel))
            WIN_A:   sel_lim_m1 = CW'(WIN0 - 1);
            WIN_B:   sel_lim_m1 = CW'(WIN1 - 1);
            WIN_C:   sel_lim_m1 = CW'(WIN2 - 1);
            default: sel_lim_m1 = CW'(WIN3 - 1);
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tx_active) begin
            // R5: a new transmission cancels the wait
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (tx_fall) begin
            // R2: arm at end of the transmitted word
            st_d.armed  = 1'b1;
            st_d.cnt    = '0;
            st_d.lim_m1 = sel_lim_m1;
        end else if (st_q.armed) begin
            if (resp_sync) begin
                // R4: response arrived in time
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else if (half_tick) begin
                if (st_q.cnt == st_q.lim_m1) begin
                    st_d.pulse = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout = st_q.pulse;

endmodule

// File: rtl/bus_resp_guard_wdog.sv
module bus_resp_guard_wdog #(
    parameter int unsigned WDOG_HALF = 1336
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic tx_active,
    input  logic tx_prev,
    input  logic inh_clr,
    output logic inhibit,
    output logic irq
);
    localparam int unsigned CW = $clog2(WDOG_HALF + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          inh;
        logic          irq;
    } wd_t;

    wd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!tx_active) begin
            // R9: any gap restarts the continuous-on measurement
            st_d.cnt = '0;
        end else if (tx_prev && half_tick && !st_q.inh) begin
            if (st_q.cnt == CW'(WDOG_HALF - 1)) begin
                // R6: long-run cutoff
                st_d.inh = 1'b1;
                st_d.irq = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (inh_clr) begin
            // R8: host release, wins over a trip in the same cycle
            st_d.inh = 1'b0;
            st_d.irq = 1'b0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit = st_q.inh;
    assign irq     = st_q.irq;

endmodule

// File: rtl/bus_resp_guard.sv
module bus_resp_guard #(
    parameter int unsigned DIV_FAST  = 8,
    parameter int unsigned DIV_SLOW  = 6,
    parameter int unsigned WIN0      = 37,
    parameter int unsigned WIN1      = 45,
    parameter int unsigned WIN2      = 101,
    parameter int unsigned WIN3      = 256,
    parameter int unsigned WDOG_HALF = 1336
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rate_sel,
    input  logic [1:0] tmo_sel,
    input  logic       tx_active,
    input  logic       resp_sync,
    input  logic       inh_clr,
    output logic       resp_timeout,
    output logic       tx_inhibit,
    output logic       tx_gate,
    output logic       tx_irq
);
    typedef struct packed {
        logic tx_prev;
    } top_t;

    top_t st_d, st_q;
    logic half_tick;
    logic tx_fall;

    always_comb begin
        st_d         = st_q;
        st_d.tx_prev = tx_active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_fall = st_q.tx_prev && !tx_active;

    bus_resp_guard_tickgen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .half_tick (half_tick)
    );

    bus_resp_guard_resp #(
        .WIN0 (WIN0),
        .WIN1 (WIN1),
        .WIN2 (WIN2),
        .WIN3 (WIN3)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .tx_active (tx_active),
        .tx_fall   (tx_fall),
        .resp_sync (resp_sync),
        .tmo_sel   (tmo_sel),
        .timeout   (resp_timeout)
    );

    bus_resp_guard_wdog #(
        .WDOG_HALF (WDOG_HALF)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .tx_active (tx_active),
        .tx_prev   (st_q.tx_prev),
        .inh_clr   (inh_clr),
        .inhibit   (tx_inhibit),
        .irq       (tx_irq)
    );

    // R7: transmitter forced off while inhibited
    assign tx_gate = tx_active && !tx_inhibit;

endmodule

// File: rtl/bus_resp_guard_sva.sv
module bus_resp_guard_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       rate_sel,
    input logic [1:0] tmo_sel,
    input logic       tx_active,
    input logic       resp_sync,
    input logic       inh_clr,
    input logic       resp_timeout,
    input logic       tx_inhibit,
    input logic       tx_gate,
    input logic       tx_irq
);
    p_one_cycle_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_timeout |=> !resp_timeout);

    p_sync_cancels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_sync |=> !resp_timeout);

    p_tx_cancels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !resp_timeout);

    p_irq_with_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_inhibit);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> !tx_gate);

    p_inhibit_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_inhibit && !inh_clr) |=> tx_inhibit);

    p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inh_clr |=> !tx_inhibit);

    p_gap_no_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !tx_inhibit) |=> !tx_irq);

endmodule

bind bus_resp_guard bus_resp_guard_sva u_sva (.*);

// File: tb/bus_resp_guard_test.sv
module bus_resp_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int DF   = 4;
    localparam int DS   = 3;
    localparam int WDOG = 60;
    localparam int WINS [4] = '{37, 45, 101, 256};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_sel = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       tx_active = 1'b0;
    logic       resp_sync = 1'b0;
    logic       inh_clr = 1'b0;
    logic       resp_timeout, tx_inhibit, tx_gate, tx_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_resp_guard #(
        .DIV_FAST (DF), .DIV_SLOW (DS), .WDOG_HALF (WDOG)
    ) uut (
        .clk (clk), .rst_n (rst_n), .rate_sel (rate_sel), .tmo_sel (tmo_sel),
        .tx_active (tx_active), .resp_sync (resp_sync), .inh_clr (inh_clr),
        .resp_timeout (resp_timeout), .tx_inhibit (tx_inhibit),
        .tx_gate (tx_gate), .tx_irq (tx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Drop tx_active, return edges from arming edge to the timeout pulse (-1 if none)
    task automatic wait_timeout(input int limit, input bit flip_sel, output int d);
        d = -1;
        tx_active = 1'b0;
        for (int k = 1; k <= limit; k++) begin
            @(posedge clk);
            #1;
            if (k == 1 && flip_sel) tmo_sel = ~tmo_sel;
            if (resp_timeout) begin
                d = k - 1;
                break;
            end
        end
    endtask

    task automatic sweep_window(input int sel, input bit rate, input bit flip);
        int div, n, d;
        div = rate ? DS : DF;
        n = WINS[sel];
        rate_sel = rate;
        tmo_sel = 2'(sel);
        tx_active = 1'b1;
        step(3);
        wait_timeout(n * div + 20, flip, d);
        // R1 R2 R10: expiry inside the window's cycle range
        chk(d >= (n - 1) * div + 1 && d <= n * div, "R2", d, n * div);
        step(1);
        chk(!resp_timeout, "R3", int'(resp_timeout), 0);
    endtask

    initial begin
        int d;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11: reset state
        chk(!resp_timeout && !tx_inhibit && !tx_irq && !tx_gate, "R11",
            {resp_timeout, tx_inhibit, tx_irq}, 0);
        step(DF * 300);
        chk(!resp_timeout, "R11", int'(resp_timeout), 0);

        // R1 R2 R10: every window at both rates
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 2; r++) begin
                sweep_window(s, r[0], 1'b0);
            end
        end
        // R1: select captured at arming
        sweep_window(1, 1'b0, 1'b1);
        sweep_window(2, 1'b1, 1'b1);

        // R4: sync cancels
        rate_sel = 1'b0;
        tmo_sel = 2'd0;
        tx_active = 1'b1;
        step(3);
        tx_active = 1'b0;
        step(20);
        resp_sync = 1'b1;
        step(1);
        resp_sync = 1'b0;
        d = 0;
        for (int k = 0; k < 300; k++) begin
            step(1);
            if (resp_timeout) d++;
        end
        chk(d == 0, "R4", d, 0);

        // R4: sync while idle has no effect
        resp_sync = 1'b1;
        step(5);
        resp_sync = 1'b0;
        chk(!resp_timeout && !tx_inhibit, "R4", int'(resp_timeout), 0);

        // R5: re-transmission restarts the window from the next fall
        tx_active = 1'b1;
        step(3);
        tx_active = 1'b0;
        step(100);
        tx_active = 1'b1;
        step(4);
        chk(!resp_timeout, "R5", int'(resp_timeout), 0);
        wait_timeout(37 * DF + 20, 1'b0, d);
        chk(d >= 36 * DF + 1 && d <= 37 * DF, "R5", d, 37 * DF);

        // R7: gate follows tx_active while not inhibited
        tx_active = 1'b1;
        step(1);
        chk(tx_gate, "R7", int'(tx_gate), 1);

        // R9: short bursts never trip
        d = 0;
        for (int b = 0; b < 4; b++) begin
            tx_active = 1'b1;
            for (int k = 0; k < (WDOG - 2) * DF; k++) begin
                step(1);
                if (tx_irq || tx_inhibit) d++;
            end
            tx_active = 1'b0;
            step(5);
        end
        chk(d == 0 && !tx_inhibit, "R9", d, 0);

        // R6: continuous transmission trips the watchdog
        rate_sel = 1'b0;
        tx_active = 1'b1;
        d = -1;
        for (int k = 1; k <= WDOG * DF + 20; k++) begin
            step(1);
            if (tx_irq) begin
                d = k - 1;
                break;
            end
        end
        chk(d >= (WDOG - 1) * DF + 1 && d <= WDOG * DF, "R6", d, WDOG * DF);
        chk(tx_inhibit, "R6", int'(tx_inhibit), 1);
        chk(!tx_gate, "R7", int'(tx_gate), 0);
        step(1);
        chk(!tx_irq, "R6", int'(tx_irq), 0);

        // R8: inhibit latched through long on-time and idle
        step(WDOG * DF * 2);
        chk(tx_inhibit && !tx_gate, "R8", int'(tx_inhibit), 1);
        tx_active = 1'b0;
        step(20);
        chk(tx_inhibit, "R8", int'(tx_inhibit), 1);
        inh_clr = 1'b1;
        step(1);
        inh_clr = 1'b0;
        chk(!tx_inhibit, "R8", int'(tx_inhibit), 0);
        tx_active = 1'b1;
        step(1);
        chk(tx_gate, "R7", int'(tx_gate), 1);

        // R8: reset also releases the inhibit (R11)
        step(WDOG * DF + 10);
        chk(tx_inhibit, "R6", int'(tx_inhibit), 1);
        rst_n = 1'b0;
        tx_active = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk(!tx_inhibit && !resp_timeout, "R11", int'(tx_inhibit), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule